// File: doc/BRIEF.md
# Serial Port Word Buffer with Threshold Interrupts

This block sits between a simple register interface and a serial shift engine. Two word queues, each eight entries deep, carry transmit words from the register side to the engine and receive words back. Software programs a fill threshold for each queue. Either queue can be emptied at once through a flush bit.

Three interrupt sources are latched in a status register: receive threshold reached, receive overrun and transmit drained. Each source has an enable bit and a write-one-to-clear bit. One combined interrupt line goes to the system. A live receive-ready bit and a receive-not-empty flag let software poll instead of waiting for the interrupt. The register side uses single-cycle read and write strobes. Read data is combinational from the current state. A read strobe on the receive data address pops one word.

Top module: `xfer_fifo_irq`

## Requirements
- R1: After reset both queues are empty, the queue control, enable and interrupt status registers read 0, `engTxValid` is 0 and `irqOut` is 0.
- R2: Each queue holds 8 words and returns them in arrival order. A transmit write (address 5) while the transmit queue holds 8 words is dropped.
- R3: The queue control register (address 0) holds the receive threshold in bits 3:0 and the transmit threshold in bits 11:8, both readable. Writing 1 to bit 4 empties the receive queue and writing 1 to bit 12 empties the transmit queue, both on the next clock. Bits 4 and 12 always read 0.
- R4: Status register (address 1) bit 0 reads 1 exactly when the receive queue is non-empty. A read strobe at address 6 returns the oldest receive word and removes it. On an empty queue that read returns 0 and changes nothing.
- R5: Interrupt status (address 3) bit 3 latches when the receive queue becomes non-empty with an occupancy of at least the receive threshold. Bit 9 reads 1 for as long as that condition holds.
- R6: Interrupt status bit 0 latches when the engine delivers a word while the receive queue holds 8 entries. That word is discarded.
- R7: Interrupt status bit 4 latches when the engine takes the last word from the transmit queue.
- R8: Writing 1 to bit 4, 3 or 0 at address 4 clears that status bit. A new event in the same cycle wins over the clear. Address 4 reads 0.
- R9: The enable register (address 2) has bits 4, 3 and 0 matching the status bits. `irqOut` is 1 when any latched status bit has its enable set. Clearing an enable leaves the status bit latched.
- R10: `engTxValid` is 1 while the transmit queue is non-empty, and `engTxData` shows its oldest word. A pulse on `engTxPop` with valid set removes that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops on address 6) |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| engTxValid | output | 1 | Transmit word available to the engine |
| engTxData | output | DATA_W | Oldest transmit word |
| engTxPop | input | 1 | Engine takes the transmit word |
| engRxPush | input | 1 | Engine delivers a receive word |
| engRxData | input | DATA_W | Received word |
| irqOut | output | 1 | Combined interrupt |

## Verification
A wrong queue pointer or count shows at the ports on the next pop: a word comes out of order, comes out twice, or is missing. The not-empty flag and `engTxValid` also disagree with the number of words written. A threshold comparison off by one raises bit 3 and bit 9 one engine push early or late. The bench checks those bits after every push around the threshold. A latch that fails to hold, or a clear that beats a same-cycle event, shows in the interrupt status read one cycle after the event.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

  localparam int REG_W = 32;
  localparam int THR_W = 4;

  localparam logic [2:0] ADDR_CTL  = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_IEN  = 3'd2;
  localparam logic [2:0] ADDR_IST  = 3'd3;
  localparam logic [2:0] ADDR_ICLR = 3'd4;
  localparam logic [2:0] ADDR_TXD  = 3'd5;
  localparam logic [2:0] ADDR_RXD  = 3'd6;

  localparam int BIT_OVR     = 0;
  localparam int BIT_RXDONE  = 3;
  localparam int BIT_TXDONE  = 4;
  localparam int BIT_RXRDY   = 9;
  localparam int BIT_RXFLUSH = 4;
  localparam int BIT_TXFLUSH = 12;
  localparam int RXTHR_LSB   = 0;
  localparam int TXTHR_LSB   = 8;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } fifoStrobe_t;

  typedef struct packed {
    logic txDone;
    logic rxDone;
    logic overrun;
  } irqBits_t;

endpackage

// File: rtl/xfer_fifo_buf.sv
module xfer_fifo_buf #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic          doPush;
  logic          doPop;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wrData;
  end

endmodule

// File: rtl/xfer_fifo_dpath.sv
module xfer_fifo_dpath
  import xfer_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxData,
  output logic              engTxValid,
  output logic [DATA_W-1:0] engTxData,
  output logic [DATA_W-1:0] rxHead,
  output logic [CW-1:0]     txCount,
  output logic [CW-1:0]     rxCount,
  output logic              rxOverrunEv,
  output logic              txDrainEv
);

  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txPopOk;

  xfer_fifo_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (strobe.txFlush),
    .push   (strobe.txPush),
    .pop    (engTxPop),
    .wrData (txWrData),
    .rdData (engTxData),
    .count  (txCount),
    .full   (txFull),
    .empty  (txEmpty)
  );

  xfer_fifo_buf #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (strobe.rxFlush),
    .push   (engRxPush),
    .pop    (strobe.rxPop),
    .wrData (engRxData),
    .rdData (rxHead),
    .count  (rxCount),
    .full   (rxFull),
    .empty  (rxEmpty)
  );

  logic unusedFlags;
  assign unusedFlags = txFull ^ rxEmpty;

  assign engTxValid  = !txEmpty;
  assign txPopOk     = engTxPop && !txEmpty;
  // The last word leaves and nothing refills the queue in the same cycle.
  assign txDrainEv   = txPopOk && (txCount == CW'(1)) && !strobe.txPush && !strobe.txFlush;
  assign rxOverrunEv = engRxPush && rxFull;

endmodule

// File: rtl/xfer_fifo_ctrl.sv
module xfer_fifo_ctrl
  import xfer_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CW     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [DATA_W-1:0] rxHead,
  input  logic [CW-1:0]     rxCount,
  input  logic              rxOverrunEv,
  input  logic              txDrainEv,
  output fifoStrobe_t       strobe,
  output irqBits_t          irqSt,
  output logic              irqOut
);

  localparam int CMPW = (CW > THR_W) ? CW : THR_W;

  logic [THR_W-1:0] rxThr;
  logic [THR_W-1:0] txThr;
  irqBits_t         irqEn;
  irqBits_t         clrMask;
  logic             wrCtl, wrIen, wrClr;
  logic             rxReady, rxReadyQ, rxRise;

  assign wrCtl = regWrEn && (regAddr == ADDR_CTL);
  assign wrIen = regWrEn && (regAddr == ADDR_IEN);
  assign wrClr = regWrEn && (regAddr == ADDR_ICLR);

  always_comb begin
    strobe.txPush  = regWrEn && (regAddr == ADDR_TXD);
    strobe.rxPop   = regRdEn && (regAddr == ADDR_RXD);
    strobe.txFlush = wrCtl && regWrData[BIT_TXFLUSH];
    strobe.rxFlush = wrCtl && regWrData[BIT_RXFLUSH];
  end

  always_comb begin
    clrMask = '0;
    if (wrClr) begin
      clrMask.txDone  = regWrData[BIT_TXDONE];
      clrMask.rxDone  = regWrData[BIT_RXDONE];
      clrMask.overrun = regWrData[BIT_OVR];
    end
  end

  assign rxReady = (rxCount != '0) && (CMPW'(rxCount) >= CMPW'(rxThr));
  assign rxRise  = rxReady && !rxReadyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxThr    <= '0;
      txThr    <= '0;
      irqEn    <= '0;
      irqSt    <= '0;
      rxReadyQ <= 1'b0;
    end else begin
      rxReadyQ <= rxReady;
      if (wrCtl) begin
        rxThr <= regWrData[RXTHR_LSB +: THR_W];
        txThr <= regWrData[TXTHR_LSB +: THR_W];
      end
      if (wrIen) begin
        irqEn.txDone  <= regWrData[BIT_TXDONE];
        irqEn.rxDone  <= regWrData[BIT_RXDONE];
        irqEn.overrun <= regWrData[BIT_OVR];
      end
      // An event in the same cycle as its clear keeps the bit set.
      irqSt.txDone  <= txDrainEv   | (irqSt.txDone  & ~clrMask.txDone);
      irqSt.rxDone  <= rxRise      | (irqSt.rxDone  & ~clrMask.rxDone);
      irqSt.overrun <= rxOverrunEv | (irqSt.overrun & ~clrMask.overrun);
    end
  end

  assign irqOut = |(irqSt & irqEn);

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CTL: begin
        regRdData[RXTHR_LSB +: THR_W] = rxThr;
        regRdData[TXTHR_LSB +: THR_W] = txThr;
      end
      ADDR_STAT: regRdData[0] = (rxCount != '0);
      ADDR_IEN: begin
        regRdData[BIT_TXDONE] = irqEn.txDone;
        regRdData[BIT_RXDONE] = irqEn.rxDone;
        regRdData[BIT_OVR]    = irqEn.overrun;
      end
      ADDR_IST: begin
        regRdData[BIT_RXRDY]  = rxReady;
        regRdData[BIT_TXDONE] = irqSt.txDone;
        regRdData[BIT_RXDONE] = irqSt.rxDone;
        regRdData[BIT_OVR]    = irqSt.overrun;
      end
      ADDR_RXD: if (rxCount != '0) regRdData[DATA_W-1:0] = rxHead;
      default: regRdData = '0;
    endcase
  end

  logic unusedBits;
  assign unusedBits = ^{regWrData[REG_W-1:BIT_TXFLUSH+1], regWrData[7:5]};

endmodule

// File: rtl/xfer_fifo_irq.sv
module xfer_fifo_irq
  import xfer_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              engTxValid,
  output logic [DATA_W-1:0] engTxData,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxData,
  output logic              irqOut
);

  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobe_t       strobe;
  irqBits_t          irqSt;
  logic [DATA_W-1:0] rxHead;
  logic [CW-1:0]     txCount;
  logic [CW-1:0]     rxCount;
  logic              rxOverrunEv;
  logic              txDrainEv;

  xfer_fifo_ctrl #(.DATA_W(DATA_W), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .rxHead      (rxHead),
    .rxCount     (rxCount),
    .rxOverrunEv (rxOverrunEv),
    .txDrainEv   (txDrainEv),
    .strobe      (strobe),
    .irqSt       (irqSt),
    .irqOut      (irqOut)
  );

  xfer_fifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .txWrData    (regWrData[DATA_W-1:0]),
    .engTxPop    (engTxPop),
    .engRxPush   (engRxPush),
    .engRxData   (engRxData),
    .engTxValid  (engTxValid),
    .engTxData   (engTxData),
    .rxHead      (rxHead),
    .txCount     (txCount),
    .rxCount     (rxCount),
    .rxOverrunEv (rxOverrunEv),
    .txDrainEv   (txDrainEv)
  );

endmodule

// File: rtl/xfer_fifo_chk.sv
module xfer_fifo_chk
  import xfer_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWrEn,
  input logic [2:0]    regAddr,
  input logic [31:0]   regWrData,
  input logic          engRxPush,
  input logic          engTxValid,
  input logic          irqOut,
  input logic [CW-1:0] rxCount,
  input logic [CW-1:0] txCount,
  input irqBits_t      irqSt
);

  a_r2_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount <= CW'(DEPTH)) && (txCount <= CW'(DEPTH)));

  a_r3_rx_flush: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CTL && regWrData[BIT_RXFLUSH]) |=> (rxCount == '0));

  a_r6_overrun_latch: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && rxCount == CW'(DEPTH)) |=> irqSt.overrun);

  a_r8_rxdone_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irqSt.rxDone && !(regWrEn && regAddr == ADDR_ICLR && regWrData[BIT_RXDONE]))
      |=> irqSt.rxDone);

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqSt != '0));

  a_r10_valid_count: assert property (@(posedge clk) disable iff (!rstN)
    engTxValid |-> (txCount != '0));

endmodule

bind xfer_fifo_irq xfer_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .engRxPush  (engRxPush),
  .engTxValid (engTxValid),
  .irqOut     (irqOut),
  .rxCount    (rxCount),
  .txCount    (txCount),
  .irqSt      (irqSt)
);

// File: tb/test_xfer_fifo_irq.sv
`timescale 1ns/1ps
module test_xfer_fifo_irq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        engTxValid;
  logic [31:0] engTxData;
  logic        engTxPop = 1'b0;
  logic        engRxPush = 1'b0;
  logic [31:0] engRxData = '0;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xfer_fifo_irq i_xfer_fifo_irq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .engTxValid(engTxValid), .engTxData(engTxData), .engTxPop(engTxPop),
    .engRxPush(engRxPush), .engRxData(engRxData), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic popRx(output logic [31:0] d);
    @(negedge clk);
    regAddr = 3'd6; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pushRx(input logic [31:0] d);
    @(negedge clk);
    engRxPush = 1'b1; engRxData = d;
    @(negedge clk);
    engRxPush = 1'b0;
  endtask

  task automatic popTx(output logic [31:0] d);
    @(negedge clk);
    d = engTxData; engTxPop = 1'b1;
    @(negedge clk);
    engTxPop = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    peek(3'd0, v); chk("R1 ctl", v, 32'h0);
    peek(3'd1, v); chk("R1 stat", v, 32'h0);
    peek(3'd2, v); chk("R1 ien", v, 32'h0);
    peek(3'd3, v); chk("R1 ist", v, 32'h0);
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);
    chk("R1 txValid", {31'b0, engTxValid}, 32'h0);
  endtask

  task automatic t_ctl_fields;
    logic [31:0] v;
    wr(3'd0, 32'h0000_1A15);
    peek(3'd0, v); chk("R3 thresholds and flush readback", v, 32'h0000_0A05);
    peek(3'd4, v); chk("R8 clear reg reads 0", v, 32'h0);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_tx_order;
    logic [31:0] v;
    for (int i = 0; i < 9; i++) wr(3'd5, 32'h100 + i);
    chk("R10 txValid after writes", {31'b0, engTxValid}, 32'h1);
    for (int i = 0; i < 8; i++) begin
      popTx(v);
      chk("R2 tx order", v, 32'h100 + i);
    end
    chk("R2 ninth tx word dropped", {31'b0, engTxValid}, 32'h0);
    peek(3'd3, v); chk("R7 tx drained flag", v & 32'h10, 32'h10);
    wr(3'd4, 32'h10);
    peek(3'd3, v); chk("R8 tx flag cleared", v & 32'h10, 32'h0);
  endtask

  task automatic t_rx_thr;
    logic [31:0] v;
    wr(3'd4, 32'h19);
    wr(3'd0, 32'h3);
    wr(3'd2, 32'h8);
    pushRx(32'hA0); pushRx(32'hA1);
    peek(3'd3, v); chk("R5 below threshold", v & 32'h208, 32'h0);
    chk("R9 no irq below threshold", {31'b0, irqOut}, 32'h0);
    peek(3'd1, v); chk("R4 not-empty flag", v, 32'h1);
    pushRx(32'hA2);
    peek(3'd3, v); chk("R5 threshold reached", v & 32'h208, 32'h208);
    chk("R9 irq on threshold", {31'b0, irqOut}, 32'h1);
    popRx(v); chk("R4 rx first word", v, 32'hA0);
    peek(3'd3, v); chk("R5 ready drops, done latched", v & 32'h208, 32'h8);
    wr(3'd4, 32'h8);
    peek(3'd3, v); chk("R8 rx done cleared", v & 32'h8, 32'h0);
    chk("R9 irq after clear", {31'b0, irqOut}, 32'h0);
    popRx(v); chk("R4 rx second word", v, 32'hA1);
    popRx(v); chk("R4 rx third word", v, 32'hA2);
    peek(3'd1, v); chk("R4 empty flag", v, 32'h0);
    popRx(v); chk("R4 empty read returns 0", v, 32'h0);
  endtask

  task automatic t_overrun;
    logic [31:0] v;
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h19);
    wr(3'd2, 32'h1);
    for (int i = 0; i < 8; i++) pushRx(32'hB0 + i);
    peek(3'd3, v); chk("R6 no overrun at 8", v & 32'h1, 32'h0);
    pushRx(32'hDEAD);
    peek(3'd3, v); chk("R6 overrun latched", v & 32'h1, 32'h1);
    chk("R9 overrun irq", {31'b0, irqOut}, 32'h1);
    wr(3'd2, 32'h0);
    chk("R9 irq off when disabled", {31'b0, irqOut}, 32'h0);
    peek(3'd3, v); chk("R9 status kept after disable", v & 32'h1, 32'h1);
    wr(3'd4, 32'h1);
    peek(3'd3, v); chk("R8 overrun cleared", v & 32'h1, 32'h0);
    @(negedge clk);
    engRxPush = 1'b1; engRxData = 32'hBEEF;
    regWrEn = 1'b1; regAddr = 3'd4; regWrData = 32'h1;
    @(negedge clk);
    engRxPush = 1'b0; regWrEn = 1'b0; regWrData = '0;
    peek(3'd3, v); chk("R8 event beats clear", v & 32'h1, 32'h1);
    for (int i = 0; i < 8; i++) begin
      popRx(v);
      chk("R6 kept words unchanged", v, 32'hB0 + i);
    end
    peek(3'd1, v); chk("R6 discarded words absent", v, 32'h0);
  endtask

  task automatic t_flush;
    logic [31:0] v;
    pushRx(32'hC0); pushRx(32'hC1); pushRx(32'hC2);
    wr(3'd5, 32'hD0); wr(3'd5, 32'hD1);
    wr(3'd0, 32'h0000_1010);
    peek(3'd1, v); chk("R3 rx flushed", v, 32'h0);
    chk("R3 tx flushed", {31'b0, engTxValid}, 32'h0);
    popRx(v); chk("R3 rx data after flush", v, 32'h0);
    wr(3'd5, 32'hE5);
    chk("R10 head after flush", engTxData, 32'hE5);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ctl_fields();
    t_tx_order();
    t_rx_thr();
    t_overrun();
    t_flush();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule